// File: doc/BRIEF.md
# Multi-Phase Switching Clock Generator

This block derives the timing for a four-channel class-D output stage from a 20 MHz reference clock. A first divider turns the reference into a synchronization clock of 4, 3.33 or 2.86 MHz. A phase sequencer counts that clock in half steps, sixteen per switching period, so the switching period is eight synchronization periods: 500, 417 or 357 kHz. On each switching period it raises a set of eight one-cycle phase strobes. The strobes are either spread 45 degrees apart or grouped onto the 0 and 180 degree points.

Several devices can share one timing source. A device in master mode drives its synchronization clock on `sync_clk`. A device in slave mode drives `sync_clk` low and re-aligns its own divider to each rising edge on `ext_sync`. Software sets a one-shot sync request on every device. The master re-zeroes its phase counter at its next synchronization boundary. A slave re-zeroes at the next incoming edge and moves its strobes half a phase step later. The request bit clears itself when alignment is done.

A slave starves when edges stop arriving. Its watchdog then raises a lost-clock flag and silences the strobes, which places the output stage in high impedance. The strobes stay silent until the master clock is present again. A new divide ratio is taken up only at a switching-period boundary, so it can be changed while audio plays.

Top module: `pwm_phase_clkgen`

## Requirements
- R1: In master mode `sync_clk` has a period of N reference cycles and is high for floor(N/2) of them. N is 5, 6 or 7 for `div_sel` codes 0, 1 and 2, and code 3 also gives 7. In slave mode `sync_clk` stays low.
- R2: `phase_strobe[0]` repeats every 8*N reference cycles, which is one switching period.
- R3: With `phase_mode`=0 (eighth-period spacing), at most one strobe is high per cycle. Strobe k+1 follows strobe k by N cycles.
- R4: With `phase_mode`=1 (half-period spacing), the even-indexed strobes fire together (pattern 0x55). The odd-indexed strobes fire together 4*N cycles later (pattern 0xAA).
- R5: A slave fed with a master's `sync_clk` is aligned by a sync on both devices. Afterwards each slave strobe lags the master's strobe by 3+floor(N/2) cycles in mode 0 and by 3+2*N cycles in mode 1. The fixed 3 cycles are the two-flop synchronizer plus the edge detector.
- R6: A one-cycle `sync_req` sets `sync_busy` in the next cycle. A master clears the bit in the same cycle that its `phase_strobe[0]` marks the re-zeroed phase. A slave clears it once the next external edge has re-zeroed it.
- R7: In slave mode, 16 reference cycles without an `ext_sync` rising edge raise `clk_lost`. The flag appears 19 cycles after the last rising edge of the master `sync_clk`. While `clk_lost` is high every strobe is low, including after reset until the first edge arrives. The flag clears once edges return, and a master never raises it.
- R8: A change of `div_sel` leaves the running switching period at its old length. The new ratio applies from the next period boundary on.
- R9: While `rst` is high, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Divide-ratio code: 0 gives 5, 1 gives 6, 2 or 3 give 7 |
| phase_mode | input | 1 | 0 gives 45-degree spacing, 1 gives 0/180-degree spacing |
| is_slave | input | 1 | 1 takes timing from `ext_sync`, 0 generates it |
| sync_req | input | 1 | One-cycle request to re-align the phase counter |
| ext_sync | input | 1 | Synchronization clock from a master device |
| sync_clk | output | 1 | Synchronization clock driven in master mode |
| phase_strobe | output | NUM_PH | One-cycle switching strobes, one per channel phase |
| sync_busy | output | 1 | Alignment pending; clears itself |
| clk_lost | output | 1 | Slave has lost the external clock; strobes are forced off |

## Verification
Some properties are checked by assertions on every cycle. These are the strobe patterns allowed in each spacing mode, silence of the strobes whenever the lost flag is up, and a master never flagging clock loss. They also cover `sync_busy` following a request, and a master's busy bit clearing together with phase zero. The exact spacings, the period lengths for each divide code and the period-boundary timing of a ratio change come only from the bench. So do the master-to-slave lag after alignment and the 19-cycle starvation delay. The bench measures these by time-stamping strobe and clock edges on a master instance and a slave instance wired together.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;

  typedef enum logic {
    PH_EIGHTH = 1'b0,
    PH_HALF   = 1'b1
  } ph_mode_e;

  // Reference-to-sync-clock divide ratio for each select code.
  function automatic logic [2:0] div_ratio(input logic [1:0] sel);
    logic [2:0] r;
    case (sel)
      2'd0:    r = 3'd5;
      2'd1:    r = 3'd6;
      default: r = 3'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_n,
  input  logic             realign,
  input  logic             drive_clk,
  output logic             step,
  output logic             at_zero,
  output logic             sync_clk
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_cur, half;

  assign half    = div_n >> 1;
  // An external edge forces the current cycle to be sub-count zero.
  assign cnt_cur = realign ? '0 : cnt_q;
  assign at_zero = (cnt_cur == '0);
  assign step    = at_zero || (cnt_cur == half);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sync_clk <= 1'b0;
    end else begin
      cnt_q    <= (cnt_cur >= div_n - ONE) ? '0 : cnt_cur + ONE;
      sync_clk <= drive_clk && (cnt_cur < half);
    end
  end

endmodule

// File: rtl/pwm_ext_watch.sv
module pwm_ext_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int WD_LIMIT    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sync,
  input  logic is_slave,
  output logic ext_edge,
  output logic play,
  output logic lost
);
  localparam int WD_W = $clog2(WD_LIMIT + 1);
  localparam logic [WD_W-1:0] LIMIT = WD_W'(WD_LIMIT);
  localparam logic [WD_W-1:0] ONE   = WD_W'(1);

  logic [SYNC_STAGES:0] sh_q;
  logic [WD_W-1:0]      wd_q, wd_nxt;
  logic                 rise, starve;

  assign rise     = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign ext_edge = is_slave & rise;
  assign wd_nxt   = rise ? '0 : ((wd_q >= LIMIT) ? LIMIT : wd_q + ONE);
  assign starve   = is_slave && (wd_nxt >= LIMIT);
  assign play     = !starve;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      wd_q <= LIMIT;
      lost <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC_STAGES-1:0], ext_sync};
      wd_q <= wd_nxt;
      lost <= starve;
    end
  end

endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm_clkgen_pkg::*;
#(
  parameter int NUM_PH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        div_sel,
  input  ph_mode_e          mode,
  input  logic              is_slave,
  input  logic              sync_req,
  input  logic              step,
  input  logic              at_zero,
  input  logic              ext_edge,
  input  logic              play,
  output logic [2:0]        div_n,
  output logic [NUM_PH-1:0] strobe,
  output logic              busy
);
  localparam int STEPS = 2 * NUM_PH;
  localparam int POS_W = $clog2(STEPS);
  localparam logic [POS_W-1:0] OFF_EIGHTH = POS_W'(1);
  localparam logic [POS_W-1:0] OFF_HALF   = POS_W'(NUM_PH / 2);
  localparam logic [POS_W-1:0] ONE        = POS_W'(1);

  logic [POS_W-1:0]  pos_q, pos_new, off_q, off_new;
  logic [NUM_PH-1:0] hit;
  logic              do_sync;

  assign do_sync = busy && step && at_zero && (is_slave ? ext_edge : 1'b1);
  assign pos_new = do_sync ? '0 : pos_q + ONE;
  assign off_new = !do_sync ? off_q :
                   !is_slave ? '0 :
                   (mode == PH_HALF) ? OFF_HALF : OFF_EIGHTH;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_tap
    localparam logic [POS_W-1:0] T_EIGHTH = POS_W'(2 * k);
    localparam logic [POS_W-1:0] T_HALF   = POS_W'((k % 2) * NUM_PH);
    logic [POS_W-1:0] tgt;
    assign tgt    = ((mode == PH_HALF) ? T_HALF : T_EIGHTH) + off_new;
    assign hit[k] = (pos_new == tgt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '1;
      off_q  <= '0;
      busy   <= 1'b0;
      div_n  <= div_ratio(div_sel);
      strobe <= '0;
    end else begin
      if (step) begin
        pos_q <= pos_new;
        off_q <= off_new;
        if (pos_new == '0) div_n <= div_ratio(div_sel);
      end
      busy   <= sync_req | (busy & ~do_sync);
      strobe <= hit & {NUM_PH{play & step}};
    end
  end

endmodule

// File: rtl/pwm_phase_clkgen.sv
module pwm_phase_clkgen
  import pwm_clkgen_pkg::*;
#(
  parameter int NUM_PH      = 8,
  parameter int WD_LIMIT    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        div_sel,
  input  logic              phase_mode,
  input  logic              is_slave,
  input  logic              sync_req,
  input  logic              ext_sync,
  output logic              sync_clk,
  output logic [NUM_PH-1:0] phase_strobe,
  output logic              sync_busy,
  output logic              clk_lost
);
  localparam int CNT_W = 3;

  logic [CNT_W-1:0] div_n;
  logic             step, at_zero, ext_edge, play;
  ph_mode_e         mode_e;

  assign mode_e = ph_mode_e'(phase_mode);

  pwm_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .div_n    (div_n),
    .realign  (ext_edge),
    .drive_clk(!is_slave),
    .step     (step),
    .at_zero  (at_zero),
    .sync_clk (sync_clk)
  );

  pwm_ext_watch #(.SYNC_STAGES(SYNC_STAGES), .WD_LIMIT(WD_LIMIT)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .ext_sync(ext_sync),
    .is_slave(is_slave),
    .ext_edge(ext_edge),
    .play    (play),
    .lost    (clk_lost)
  );

  pwm_phase_seq #(.NUM_PH(NUM_PH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .div_sel (div_sel),
    .mode    (mode_e),
    .is_slave(is_slave),
    .sync_req(sync_req),
    .step    (step),
    .at_zero (at_zero),
    .ext_edge(ext_edge),
    .play    (play),
    .div_n   (div_n),
    .strobe  (phase_strobe),
    .busy    (sync_busy)
  );

endmodule

// File: rtl/pwm_phase_clkgen_chk.sv
module pwm_phase_clkgen_chk #(
  parameter int NUM_PH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              phase_mode,
  input logic              is_slave,
  input logic              sync_req,
  input logic              sync_clk,
  input logic [NUM_PH-1:0] phase_strobe,
  input logic              sync_busy,
  input logic              clk_lost
);
  localparam logic [NUM_PH-1:0] EVEN = {(NUM_PH / 2){2'b01}};
  localparam logic [NUM_PH-1:0] ODD  = {(NUM_PH / 2){2'b10}};

  AST_CLK_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (is_slave && $past(is_slave)) |-> !sync_clk);  // R1

  AST_EIGHTH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    !$past(phase_mode) |-> $onehot0(phase_strobe));  // R3

  AST_HALF_PAIRS: assert property (@(posedge clk) disable iff (rst)
    $past(phase_mode) |-> (phase_strobe == '0 || phase_strobe == EVEN || phase_strobe == ODD));  // R4

  AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> sync_busy);  // R6

  AST_MASTER_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (!is_slave && $past(!is_slave) && $fell(sync_busy)) |-> phase_strobe[0]);  // R6

  AST_HIZ_WHEN_LOST: assert property (@(posedge clk) disable iff (rst)
    clk_lost |-> (phase_strobe == '0));  // R7

  AST_MASTER_NEVER_LOST: assert property (@(posedge clk) disable iff (rst)
    !is_slave |=> !clk_lost);  // R7

endmodule

bind pwm_phase_clkgen pwm_phase_clkgen_chk #(.NUM_PH(NUM_PH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase_mode  (phase_mode),
  .is_slave    (is_slave),
  .sync_req    (sync_req),
  .sync_clk    (sync_clk),
  .phase_strobe(phase_strobe),
  .sync_busy   (sync_busy),
  .clk_lost    (clk_lost)
);

// File: tb/pwm_phase_clkgen_test.sv
`timescale 1ns/1ps
module pwm_phase_clkgen_test;

  // {div_sel[7:6], phase_mode[5], unused[4], N[3:0]}
  localparam logic [7:0] VEC [6] = '{8'h05, 8'h46, 8'h87, 8'hC7, 8'h25, 8'hA7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] div_sel = 2'd0;
  logic phase_mode = 1'b0;
  logic uut_slave = 1'b0;
  logic sync_req = 1'b0;
  logic ext_en = 1'b0;

  logic       u_sync_clk, u_busy, u_lost, m_sync_clk, m_busy, m_lost;
  logic [7:0] u_strobe, m_strobe;
  logic       ext_sync;

  longint cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  assign ext_sync = ext_en & m_sync_clk;

  pwm_phase_clkgen uut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .phase_mode(phase_mode),
    .is_slave(uut_slave), .sync_req(sync_req), .ext_sync(ext_sync),
    .sync_clk(u_sync_clk), .phase_strobe(u_strobe), .sync_busy(u_busy),
    .clk_lost(u_lost)
  );

  pwm_phase_clkgen m_ref (
    .clk(clk), .rst(rst), .div_sel(div_sel), .phase_mode(phase_mode),
    .is_slave(1'b0), .sync_req(sync_req), .ext_sync(1'b0),
    .sync_clk(m_sync_clk), .phase_strobe(m_strobe), .sync_busy(m_busy),
    .clk_lost(m_lost)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: return u_strobe[0];
      1: return u_strobe[1];
      2: return m_strobe[0];
      3: return u_sync_clk;
      4: return m_sync_clk;
      5: return u_lost;
      6: return m_busy;
      default: return u_busy;
    endcase
  endfunction

  task automatic wait_sig(input int which, input logic val, output longint t);
    do @(negedge clk); while (pick(which) !== val);
    t = cyc;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // Align master and slave; expect slave strobe0 to lag by exp_lag.
  task automatic sync_pair(input longint exp_lag);
    longint t, tm, ts;
    wait_sig(4, 1'b0, t);
    wait_sig(4, 1'b1, t);
    wait_sig(4, 1'b0, t);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    check("R6 slave busy after request", u_busy, 1);
    check("R6 master busy after request", m_busy, 1);
    wait_sig(6, 1'b0, tm);
    check("R6 master busy clears with strobe0", m_strobe[0], 1);
    wait_sig(7, 1'b0, t);
    wait_sig(0, 1'b1, ts);
    check("R5 slave lag after sync", ts - tm, exp_lag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (run hung): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    longint t0, t1, t2, tr1, tf, tr2, t;
    int nz;

    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 sync_clk in reset", u_sync_clk, 0);
    check("R9 strobes in reset", u_strobe, 0);
    check("R9 busy in reset", u_busy, 0);
    check("R9 lost in reset", u_lost, 0);
    rst = 1'b0;

    // R1..R4: master timing per divide code and spacing mode
    for (int i = 0; i < 6; i++) begin
      int n;
      n = int'(VEC[i][3:0]);
      div_sel = VEC[i][7:6];
      phase_mode = VEC[i][5];
      wait_sig(0, 1'b1, t);
      wait_sig(0, 1'b1, t);
      wait_sig(0, 1'b1, t0);
      check("R3/R4 strobe pattern at phase 0", u_strobe, VEC[i][5] ? 8'h55 : 8'h01);
      wait_sig(1, 1'b1, t1);
      check("R3/R4 gap strobe0 to strobe1", t1 - t0, VEC[i][5] ? 4 * n : n);
      if (VEC[i][5]) check("R4 odd pattern", u_strobe, 8'hAA);
      wait_sig(0, 1'b1, t2);
      check("R2 switching period", t2 - t0, 8 * n);
      wait_sig(3, 1'b0, t);
      wait_sig(3, 1'b1, tr1);
      wait_sig(3, 1'b0, tf);
      wait_sig(3, 1'b1, tr2);
      check("R1 sync_clk period", tr2 - tr1, n);
      check("R1 sync_clk high time", tf - tr1, n / 2);
    end

    // R8: ratio change lands on a period boundary
    div_sel = 2'd0;
    phase_mode = 1'b0;
    wait_sig(0, 1'b1, t);
    wait_sig(0, 1'b1, t);
    wait_sig(0, 1'b1, t0);
    repeat (7) @(negedge clk);
    div_sel = 2'd2;
    wait_sig(0, 1'b1, t1);
    wait_sig(0, 1'b1, t2);
    check("R8 period keeps old ratio", t1 - t0, 40);
    check("R8 next period uses new ratio", t2 - t1, 56);

    // R7: slave starts lost and silent until the master clock arrives
    rst = 1'b1;
    uut_slave = 1'b1;
    ext_en = 1'b0;
    div_sel = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 lost after reset without clock", u_lost, 1);
    check("R1 slave sync_clk low", u_sync_clk, 0);
    nz = 0;
    repeat (60) begin
      @(negedge clk);
      if (u_strobe != 0) nz++;
    end
    check("R7 no strobes before master clock", nz, 0);
    t0 = cyc;
    ext_en = 1'b1;
    wait_sig(5, 1'b0, t);
    check("R7 lost clears once edges arrive", (t - t0) <= 18, 1);
    wait_sig(2, 1'b1, t);
    wait_sig(2, 1'b1, t);

    // R5/R6: alignment in both spacing modes (N = 6)
    sync_pair(3 + 3);
    phase_mode = 1'b1;
    wait_sig(2, 1'b1, t);
    wait_sig(2, 1'b1, t);
    sync_pair(3 + 12);

    // R7: starvation timing and silence
    phase_mode = 1'b0;
    wait_sig(4, 1'b0, t);
    wait_sig(4, 1'b1, tr1);
    wait_sig(4, 1'b0, t);
    ext_en = 1'b0;
    wait_sig(5, 1'b1, t);
    check("R7 lost delay after last edge", t - tr1, 19);
    nz = 0;
    repeat (40) begin
      @(negedge clk);
      if (u_strobe != 0) nz++;
    end
    check("R7 strobes silent while lost", nz, 0);
    check("R7 master never lost", m_lost, 0);
    ext_en = 1'b1;
    t0 = cyc;
    wait_sig(5, 1'b0, t);
    check("R7 recovery after clock returns", (t - t0) <= 12, 1);

    summary();
    $finish;
  end

endmodule